// File: doc/BRIEF.md
# Per-Pin Interrupt Detector for an 8-Bit I/O Port

This block watches the synchronized pin levels of an 8-bit port and turns chosen conditions on them into interrupt status. Three per-pin configuration bits choose the condition for each pin: a sense bit picks level or edge detection, a both-edges bit widens edge detection to either transition, and an event bit picks the polarity. The polarity is the active level for level detection and the edge direction (rising or falling) for single-edge detection. Detected conditions set bits in a sticky raw status register. Software clears those bits by writing ones to a clear register. A mask register gates the status into a masked view and into one combined, registered interrupt output.

The port logic supplies the pin data (already synchronized) and its direction bits. Edge detection is suppressed on pins driven as outputs. Software reaches the configuration and status through a small memory-mapped register interface with a single-cycle write strobe and a combinational read port. Level-sensitive pins set their status again on every cycle that the active level persists, so a clear has no lasting effect until the source goes away.

Top module: `gpio_irq_detect`

## Requirements
- R1: With sense bit 0 and both-edges bit 0, a change on a pin sets its raw status bit only when the new level equals its event bit (event 1 means rising, event 0 means falling). The opposite edge leaves the bit unchanged.
- R2: With sense bit 0 and both-edges bit 1, any change of the pin level sets its raw status bit.
- R3: With sense bit 1, the raw status bit is set on every clock where the pin level equals its event bit. It therefore reads 1 again right after a clear while that level persists, and can be cleared once the level differs.
- R4: On a pin whose direction bit is 1 (output), level changes never set the raw status bit through edge detection.
- R5: Writing to the clear register (offset 0x41C) clears exactly the raw status bits written as 1 and keeps all other bits.
- R6: When a detected condition and a clear of the same bit occur in the same clock, the bit stays set.
- R7: The masked status register (offset 0x418) reads raw status AND mask.
- R8: The output irqOut is registered. It equals the OR of (raw status AND mask) as they stood one clock earlier.
- R9: After reset, sense, both-edges, event, mask and raw status all read 0, and irqOut is 0.
- R10: Offsets are 0x404 sense, 0x408 both-edges, 0x40C event, 0x410 mask (all read/write), 0x414 raw status (read-only), 0x418 masked status (read-only) and 0x41C clear (write-only). Data is bits 7:0, with bit n for pin n. Reads of any other offset return 0, and writes to other offsets change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| pinData | input | 8 | Synchronized pin levels |
| pinDir | input | 8 | Direction per pin, 1 = output |
| busAddr | input | 12 | Register byte offset |
| busWrEn | input | 1 | Write strobe, one clock per write |
| busWrData | input | 8 | Write data |
| busRdData | output | 8 | Read data for busAddr (combinational) |
| irqOut | output | 1 | Combined masked interrupt, registered |

## Verification
The assertions assume that pinData and pinDir are synchronous to clk and stable around the clock edge. They also assume that at least one clock edge passes in reset, so that the past values they compare against are reset values. The bench changes pins, direction and bus fields only on the falling edge and holds reset over several edges. It mixes random pin patterns, random direction bits and random register writes, including clears that collide with fresh edges, into this one legal regime. Directed steps cover each sense, edge and polarity combination explicitly.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

  localparam logic [11:0] OFF_SENSE  = 12'h404;
  localparam logic [11:0] OFF_BOTH   = 12'h408;
  localparam logic [11:0] OFF_EVENT  = 12'h40C;
  localparam logic [11:0] OFF_MASK   = 12'h410;
  localparam logic [11:0] OFF_RAW    = 12'h414;
  localparam logic [11:0] OFF_MASKED = 12'h418;
  localparam logic [11:0] OFF_CLEAR  = 12'h41C;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_SENSE,
    SEL_BOTH,
    SEL_EVENT,
    SEL_MASK,
    SEL_RAW,
    SEL_MASKED
  } rdSel_e;

  typedef struct packed {
    logic wrSense;
    logic wrBoth;
    logic wrEvent;
    logic wrMask;
    logic wrClear;
  } regStrobes_t;

endpackage

// File: rtl/gpio_irq_ctrl.sv
module gpio_irq_ctrl
  import gpio_irq_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  output regStrobes_t       strobes,
  output rdSel_e            rdSel
);

  function automatic logic hit(input logic [ADDR_W-1:0] a, input logic [11:0] off);
    return a == ADDR_W'(off);
  endfunction

  // Write strobes: one per writable register, at most one active
  always_comb begin
    strobes         = '0;
    strobes.wrSense = busWrEn && hit(busAddr, OFF_SENSE);
    strobes.wrBoth  = busWrEn && hit(busAddr, OFF_BOTH);
    strobes.wrEvent = busWrEn && hit(busAddr, OFF_EVENT);
    strobes.wrMask  = busWrEn && hit(busAddr, OFF_MASK);
    strobes.wrClear = busWrEn && hit(busAddr, OFF_CLEAR);
  end

  // Read selection; unmapped and write-only offsets select nothing
  always_comb begin
    rdSel = SEL_NONE;
    if      (hit(busAddr, OFF_SENSE))  rdSel = SEL_SENSE;
    else if (hit(busAddr, OFF_BOTH))   rdSel = SEL_BOTH;
    else if (hit(busAddr, OFF_EVENT))  rdSel = SEL_EVENT;
    else if (hit(busAddr, OFF_MASK))   rdSel = SEL_MASK;
    else if (hit(busAddr, OFF_RAW))    rdSel = SEL_RAW;
    else if (hit(busAddr, OFF_MASKED)) rdSel = SEL_MASKED;
  end

endmodule

// File: rtl/gpio_irq_datapath.sv
module gpio_irq_datapath
  import gpio_irq_pkg::*;
#(
  parameter int PINS = 8
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic [PINS-1:0] pinData,
  input  logic [PINS-1:0] pinDir,
  input  logic [PINS-1:0] wrData,
  input  regStrobes_t     strobes,
  input  rdSel_e          rdSel,
  output logic [PINS-1:0] rdData,
  output logic            irqOut
);

  logic [PINS-1:0] senseQ, bothQ, eventQ, maskQ, rawQ, prevPin;
  logic [PINS-1:0] edgeHit, levelHit, clrBits, rawNext;
  logic            irqQ;

  // Per-pin condition detection
  for (genvar i = 0; i < PINS; i++) begin : g_pin
    logic inChange, levelMatch;
    assign inChange    = (pinData[i] ^ prevPin[i]) & ~pinDir[i];
    assign levelMatch  = (pinData[i] == eventQ[i]);
    assign edgeHit[i]  = inChange & ~senseQ[i] & (bothQ[i] | levelMatch);
    assign levelHit[i] = senseQ[i] & levelMatch;
  end

  assign clrBits = strobes.wrClear ? wrData : '0;
  // New detections take priority over a simultaneous clear
  assign rawNext = (rawQ & ~clrBits) | edgeHit | levelHit;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      senseQ  <= '0;
      bothQ   <= '0;
      eventQ  <= '0;
      maskQ   <= '0;
      rawQ    <= '0;
      prevPin <= '0;
      irqQ    <= 1'b0;
    end else begin
      if (strobes.wrSense) senseQ <= wrData;
      if (strobes.wrBoth)  bothQ  <= wrData;
      if (strobes.wrEvent) eventQ <= wrData;
      if (strobes.wrMask)  maskQ  <= wrData;
      rawQ    <= rawNext;
      prevPin <= pinData;
      irqQ    <= |(rawQ & maskQ);
    end
  end

  assign irqOut = irqQ;

  always_comb begin
    unique case (rdSel)
      SEL_SENSE:  rdData = senseQ;
      SEL_BOTH:   rdData = bothQ;
      SEL_EVENT:  rdData = eventQ;
      SEL_MASK:   rdData = maskQ;
      SEL_RAW:    rdData = rawQ;
      SEL_MASKED: rdData = rawQ & maskQ;
      default:    rdData = '0;
    endcase
  end

  // Checker state: one clock seen since reset
  logic pastValid;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) pastValid <= 1'b0;
    else       pastValid <= 1'b1;
  end

  // R5: a status bit only drops after a clear strobe
  a_r5_no_spontaneous_clear: assert property (@(posedge clk) disable iff (!rstN)
    (pastValid && !$past(strobes.wrClear)) |-> ((~rawQ & $past(rawQ)) == '0));

  // R6 and R3: every detected condition is visible in the status next clock
  a_r6_detect_beats_clear: assert property (@(posedge clk) disable iff (!rstN)
    pastValid |-> (($past(edgeHit | levelHit) & ~rawQ) == '0));

  // R4: edge-sensitive output pins never gain a status bit
  a_r4_output_pins_quiet: assert property (@(posedge clk) disable iff (!rstN)
    pastValid |-> ((rawQ & ~$past(rawQ) & ~$past(senseQ) & $past(pinDir)) == '0));

  // R8: an all-zero mask keeps the output low one clock later
  a_r8_masked_off_quiet: assert property (@(posedge clk) disable iff (!rstN)
    (pastValid && ($past(maskQ) == '0)) |-> !irqOut);

  // R7: the masked view never shows a bit absent from raw status
  a_r7_masked_subset: assert property (@(posedge clk) disable iff (!rstN)
    (rdSel == SEL_MASKED) |-> ((rdData & ~rawQ) == '0));

endmodule

// File: rtl/gpio_irq_detect.sv
module gpio_irq_detect
  import gpio_irq_pkg::*;
#(
  parameter int PINS   = 8,
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [PINS-1:0]   pinData,
  input  logic [PINS-1:0]   pinDir,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  input  logic [PINS-1:0]   busWrData,
  output logic [PINS-1:0]   busRdData,
  output logic              irqOut
);

  regStrobes_t strobes;
  rdSel_e      rdSel;

  gpio_irq_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .busAddr (busAddr),
    .busWrEn (busWrEn),
    .strobes (strobes),
    .rdSel   (rdSel)
  );

  gpio_irq_datapath #(.PINS(PINS)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .pinData (pinData),
    .pinDir  (pinDir),
    .wrData  (busWrData),
    .strobes (strobes),
    .rdSel   (rdSel),
    .rdData  (busRdData),
    .irqOut  (irqOut)
  );

endmodule

// File: tb/gpio_irq_detect_tb.sv
`timescale 1ns/1ps
module gpio_irq_detect_tb;

  localparam logic [11:0] A_SENSE = 12'h404, A_BOTH = 12'h408, A_EVENT = 12'h40C,
                          A_MASK = 12'h410, A_RAW = 12'h414, A_MASKED = 12'h418,
                          A_CLEAR = 12'h41C, A_UNMAPPED = 12'h420;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [7:0]  pinData = '0, pinDir = '0, busWrData = '0;
  logic [11:0] busAddr = '0;
  logic        busWrEn = 1'b0;
  logic [7:0]  busRdData;
  logic        irqOut;

  always #4 clk = ~clk;

  gpio_irq_detect u_dut (
    .clk(clk), .rstN(rstN), .pinData(pinData), .pinDir(pinDir),
    .busAddr(busAddr), .busWrEn(busWrEn), .busWrData(busWrData),
    .busRdData(busRdData), .irqOut(irqOut)
  );

  int    nChecks = 0, nFails = 0;
  string curTag = "R9";

  // Bench model of the requirements
  logic [7:0] mSense = '0, mBoth = '0, mEvent = '0, mMask = '0, mRaw = '0, mPrev = '0;
  logic       mIrq = 1'b0;
  logic [7:0] curPin = '0, curDir = '0;

  function automatic logic [7:0] detectHits(input logic [7:0] p, d, prev, sen, bth, evt);
    logic [7:0] chg;
    chg = (p ^ prev) & ~d;
    return (chg & ~sen & (bth | ~(p ^ evt))) | (sen & ~(p ^ evt));
  endfunction

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic readExpect(input logic [11:0] a, input logic [7:0] exp, input string req);
    busWrEn = 1'b0;
    busAddr = a;
    #1;
    check(req, busRdData, exp);
  endtask

  // One clock: apply inputs at the falling edge, update the model, check after the edge
  task automatic step(input logic [7:0] p, input logic [7:0] d, input logic w,
                      input logic [11:0] a, input logic [7:0] wd);
    logic [7:0] clr;
    pinData = p; pinDir = d; busWrEn = w; busAddr = a; busWrData = wd;
    curPin = p; curDir = d;
    clr  = (w && a == A_CLEAR) ? wd : 8'h00;
    mIrq = |(mRaw & mMask);
    mRaw = (mRaw & ~clr) | detectHits(p, d, mPrev, mSense, mBoth, mEvent);
    mPrev = p;
    if (w) begin
      case (a)
        A_SENSE: mSense = wd;
        A_BOTH:  mBoth  = wd;
        A_EVENT: mEvent = wd;
        A_MASK:  mMask  = wd;
        default: ;
      endcase
    end
    @(posedge clk);
    @(negedge clk);
    busWrEn = 1'b0;
    check({curTag, " R8 irqOut"}, {7'd0, irqOut}, {7'd0, mIrq});
    readExpect(A_RAW, mRaw, {curTag, " raw"});
  endtask

  task automatic wr(input logic [11:0] a, input logic [7:0] wd);
    step(curPin, curDir, 1'b1, a, wd);
  endtask

  task automatic pins(input logic [7:0] p);
    step(p, curDir, 1'b0, A_RAW, 8'h00);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin : main
    repeat (4) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;

    // R9: reset state
    readExpect(A_SENSE, 8'h00, "R9 sense");
    readExpect(A_BOTH, 8'h00, "R9 both");
    readExpect(A_EVENT, 8'h00, "R9 event");
    readExpect(A_MASK, 8'h00, "R9 mask");
    readExpect(A_RAW, 8'h00, "R9 raw");
    readExpect(A_MASKED, 8'h00, "R9 masked");
    check("R9 irqOut", {7'd0, irqOut}, 8'h00);

    // R10: register map, unmapped offsets inert
    curTag = "R10";
    wr(A_SENSE, 8'hA5); wr(A_BOTH, 8'h3C); wr(A_EVENT, 8'h81); wr(A_MASK, 8'h7E);
    wr(A_UNMAPPED, 8'hFF);
    readExpect(A_SENSE, 8'hA5, "R10 sense");
    readExpect(A_BOTH, 8'h3C, "R10 both");
    readExpect(A_EVENT, 8'h81, "R10 event");
    readExpect(A_MASK, 8'h7E, "R10 mask");
    readExpect(A_UNMAPPED, 8'h00, "R10 unmapped read");
    readExpect(A_CLEAR, 8'h00, "R10 clear reads zero");
    wr(A_SENSE, 8'h00); wr(A_BOTH, 8'h00); wr(A_EVENT, 8'h00);
    wr(A_CLEAR, 8'hFF); wr(A_MASK, 8'hFF);

    // R1: single-edge polarity
    curTag = "R1";
    wr(A_EVENT, 8'h01);
    pins(8'h01);
    readExpect(A_RAW, 8'h01, "R1 rising on event 1");
    wr(A_CLEAR, 8'h01);
    pins(8'h00);
    readExpect(A_RAW, 8'h00, "R1 falling ignored on event 1");
    pins(8'h02);
    readExpect(A_RAW, 8'h00, "R1 rising ignored on event 0");
    pins(8'h00);
    readExpect(A_RAW, 8'h02, "R1 falling on event 0");
    wr(A_CLEAR, 8'hFF);

    // R8: latency of irqOut
    curTag = "R8";
    pins(8'h01);
    check("R8 irq not yet", {7'd0, irqOut}, 8'h00);
    pins(8'h01);
    check("R8 irq one clock later", {7'd0, irqOut}, 8'h01);
    wr(A_CLEAR, 8'hFF); pins(8'h00); wr(A_CLEAR, 8'hFF);

    // R2: both edges
    curTag = "R2";
    wr(A_BOTH, 8'h04);
    pins(8'h04);
    readExpect(A_RAW, 8'h04, "R2 rising");
    wr(A_CLEAR, 8'h04);
    pins(8'h00);
    readExpect(A_RAW, 8'h04, "R2 falling");
    wr(A_CLEAR, 8'h04);

    // R4: output pins never edge-detect
    curTag = "R4";
    step(8'h00, 8'h08, 1'b1, A_BOTH, 8'h08);
    pins(8'h08); pins(8'h00);
    readExpect(A_RAW, 8'h00, "R4 output pin toggles ignored");
    step(8'h00, 8'h00, 1'b0, A_RAW, 8'h00);

    // R3: level re-assertion
    curTag = "R3";
    wr(A_SENSE, 8'h10); wr(A_EVENT, 8'h10);
    pins(8'h10);
    readExpect(A_RAW, 8'h10, "R3 level set");
    wr(A_CLEAR, 8'h10);
    readExpect(A_RAW, 8'h10, "R3 reasserted after clear");
    pins(8'h00);
    wr(A_CLEAR, 8'h10);
    readExpect(A_RAW, 8'h00, "R3 cleared once level gone");
    wr(A_SENSE, 8'h00);

    // R6: detection beats same-cycle clear
    curTag = "R6";
    wr(A_BOTH, 8'h20);
    step(8'h20, 8'h00, 1'b1, A_CLEAR, 8'h20);
    readExpect(A_RAW, 8'h20, "R6 edge wins over clear");

    // R5: clear only the written ones
    curTag = "R5";
    wr(A_BOTH, 8'hC0);
    pins(8'hE0);
    readExpect(A_RAW, 8'hE0, "R5 setup");
    wr(A_CLEAR, 8'h40);
    readExpect(A_RAW, 8'hA0, "R5 partial clear");

    // R7: masked view
    curTag = "R7";
    wr(A_MASK, 8'h0F);
    readExpect(A_MASKED, 8'h00, "R7 masked none");
    pins(8'hE0);
    check("R7 irq low when masked", {7'd0, irqOut}, 8'h00);
    wr(A_MASK, 8'h20);
    readExpect(A_MASKED, 8'h20, "R7 masked one bit");
    wr(A_CLEAR, 8'hFF);

    // Random phase: pins, direction and register writes mixed
    curTag = "R1 R2 R3 R4 R5 R6 random";
    void'($urandom(32'd20240611));
    for (int n = 0; n < 3000; n++) begin
      logic [7:0]  rp, rd, rv;
      logic        rw;
      logic [11:0] ra;
      int          pick;
      rp = ($urandom_range(0, 3) == 0) ? 8'($urandom) : curPin ^ (8'h01 << $urandom_range(0, 7));
      rd = ($urandom_range(0, 15) == 0) ? 8'($urandom) : curDir;
      rw = ($urandom_range(0, 2) == 0);
      pick = $urandom_range(0, 5);
      case (pick)
        0: ra = A_SENSE;
        1: ra = A_BOTH;
        2: ra = A_EVENT;
        3: ra = A_MASK;
        4: ra = A_CLEAR;
        default: ra = A_UNMAPPED;
      endcase
      rv = 8'($urandom);
      step(rp, rd, rw, ra, rv);
      if (n % 16 == 0) readExpect(A_MASKED, mRaw & mMask, "R7 random masked");
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

endmodule